// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-mapped master for the two-wire PHY management bus. Software loads one packed 32-bit frame word, and that write alone starts a transaction. The block sends 32 idle-high preamble bits and then the 32 frame bits, most significant bit first, on the data line. The management clock is divided down from the system clock by a programmable speed value.

On a read, the master releases the data line during the turnaround. It captures the sixteen bits the PHY returns and places them in the low half of the same frame word. When a frame ends, an event flag is set. Software clears that flag by writing a one to it, and a mask bit decides whether the flag reaches the interrupt output.

Register map (word select `reg_addr`): 0 = frame word, 1 = event (bit 0), 2 = interrupt mask (bit 0), 3 = speed (low `SPD_W` bits). The frame word is laid out as follows: bits 31:30 start code 01, bits 29:28 opcode (10 = read, any other value is sent as a write), bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround 10, bits 15:0 data. `reg_rdata` is registered and returns the word selected by `reg_addr` one clock later.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `mdc`, `mdio_oe` and `irq` are 0, and all four registers read as 0.
- R2: A write to the frame word, while the speed is nonzero and no frame is active, starts a frame. The frame opens with 32 bits of 1, all driven with `mdio_oe` high.
- R3: After the preamble, frame bits 31 down to 0 are sent in order. `mdio_o` changes only at the system clock edge where `mdc` falls, so it is stable at every `mdc` rising edge.
- R4: With speed value S, `mdc` stays high for S system clocks and low for S system clocks, giving a period of 2·S. Between frames `mdc` is held low.
- R5: For opcode 10, `mdio_oe` is 0 from the frame's bit 16 (the second turnaround bit) through bit 0. Whenever no frame is active, `mdio_oe` is 0.
- R6: On a read, `mdio_i` is sampled at each `mdc` rising edge during frame bits 15..0, with the first sample going to bit 15. The frame word's bits 15:0 then hold the sampled value, and bits 31:16 keep their written value. A write frame leaves the frame word as it was written.
- R7: At the end of every frame, event bit 0 becomes 1. Writing 1 to event bit 0 clears it, and writing 0 has no effect.
- R8: `irq` is the registered AND of the event bit and mask bit 0. The mask has no effect on the event bit.
- R9: While the speed is 0, a frame word write is ignored. No `mdc` edge occurs, no event is raised and the frame word is unchanged.
- R10: A frame word write while a frame is active is ignored. The active frame continues unchanged, and the frame word's bits 31:16 are unchanged.
- R11: When completion and a write-1 clear of the event fall in the same cycle, the event is set.
- R12: An opcode other than 10 is transmitted with `mdio_oe` high for every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |
| irq | output | 1 | Masked completion interrupt |

## Verification
Frame completion, which sets the event, and a software write-1 clear of that event can land on the same clock edge. To provoke this, the bench holds a clear write asserted on every cycle across the whole end of a read frame, with the mask set. If the set wins, the event survives exactly one cycle, and that shows as an `irq` pulse during the clearing window. After the window the event must read 0. Throughout, a scoreboard compares every bit seen at an `mdc` rising edge, both `mdio_o` and `mdio_oe`, with the expected preamble and frame, and it also checks the clock period on each edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int OP_HI   = 29;
  localparam int OP_LO   = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_EVENT = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_SPEED = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int SPD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SPD_W-1:0] div_in,
  input  logic             run,
  output logic             mdc,
  output logic             tick_rise,
  output logic             tick_fall
);

  logic [SPD_W-1:0] div_q;
  logic [SPD_W-1:0] cnt;
  logic [SPD_W-1:0] cnt_last;
  logic             tick;

  always_comb begin
    cnt_last  = div_q - SPD_W'(1);
    tick      = run && (cnt == cnt_last);
    tick_rise = tick && !mdc;
    tick_fall = tick && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt   <= '0;
      mdc   <= 1'b0;
    end else begin
      if (load) div_q <= div_in;
      if (!run) begin
        cnt <= '0;
        mdc <= 1'b0;
      end else if (tick) begin
        cnt <= '0;
        mdc <= ~mdc;
      end else begin
        cnt <= cnt + SPD_W'(1);
      end
    end
  end

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               tick_rise,
  input  logic               tick_fall,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic               rd_done,
  output logic [DATA_W-1:0]  rd_word
);

  localparam int TOTAL = PRE_BITS + FRAME_W;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(PRE_BITS + 15);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_BITS + 16);

  logic [TOTAL-1:0]  preload;
  logic [TOTAL-1:0]  sh;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  idx_nx;
  logic              is_rd;
  logic [DATA_W-1:0] cap;

  generate
    if (PRE_BITS > 0) begin : g_pre
      assign preload = {{PRE_BITS{1'b1}}, frame_in};
    end else begin : g_nopre
      assign preload = frame_in;
    end
  endgenerate

  assign idx_nx  = idx + IDX_W'(1);
  assign rd_word = cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      cap     <= '0;
      busy    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      done    <= 1'b0;
      rd_done <= 1'b0;
      if (start && !busy) begin
        sh      <= preload;
        idx     <= '0;
        is_rd   <= (frame_in[OP_HI:OP_LO] == OP_READ);
        busy    <= 1'b1;
        mdio_o  <= preload[TOTAL-1];
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (tick_rise && is_rd && (idx >= DAT_IDX)) begin
          cap <= {cap[DATA_W-2:0], mdio_i};
        end
        if (tick_fall) begin
          if (idx == LAST_IDX) begin
            busy    <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b1;
            rd_done <= is_rd;
          end else begin
            sh      <= {sh[TOTAL-2:0], 1'b0};
            mdio_o  <= sh[TOTAL-2];
            idx     <= idx_nx;
            mdio_oe <= !(is_rd && (idx_nx >= REL_IDX));
          end
        end
      end
    end
  end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int SPD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               busy,
  input  logic               done,
  input  logic               rd_done,
  input  logic [DATA_W-1:0]  rd_word,
  output logic               start,
  output logic [FRAME_W-1:0] frame_q,
  output logic [SPD_W-1:0]   speed_q,
  output logic               evt_bit,
  output logic               mask_bit,
  output logic               irq
);

  logic wr_frame, wr_event, wr_mask, wr_speed;

  always_comb begin
    wr_frame = reg_wr && (reg_addr == SEL_FRAME);
    wr_event = reg_wr && (reg_addr == SEL_EVENT);
    wr_mask  = reg_wr && (reg_addr == SEL_MASK);
    wr_speed = reg_wr && (reg_addr == SEL_SPEED);
    start    = wr_frame && !busy && (speed_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q  <= '0;
      speed_q  <= '0;
      evt_bit  <= 1'b0;
      mask_bit <= 1'b0;
      irq      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (start)        frame_q <= reg_wdata;
      else if (rd_done) frame_q[DATA_W-1:0] <= rd_word;

      if (done)                       evt_bit <= 1'b1;
      else if (wr_event && reg_wdata[0]) evt_bit <= 1'b0;

      if (wr_mask)  mask_bit <= reg_wdata[0];
      if (wr_speed) speed_q  <= reg_wdata[SPD_W-1:0];

      irq <= evt_bit & mask_bit;

      case (reg_addr)
        SEL_FRAME: reg_rdata <= frame_q;
        SEL_EVENT: reg_rdata <= {31'd0, evt_bit};
        SEL_MASK:  reg_rdata <= {31'd0, mask_bit};
        default:   reg_rdata <= {{(32-SPD_W){1'b0}}, speed_q};
      endcase
    end
  end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int SPD_W    = 8,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);

  logic               busy;
  logic               start;
  logic               done;
  logic               rd_done;
  logic [DATA_W-1:0]  rd_word;
  logic [FRAME_W-1:0] frame_q;
  logic [SPD_W-1:0]   speed_q;
  logic               evt_bit;
  logic               mask_bit;
  logic               tick_rise;
  logic               tick_fall;

  mdio_regs #(.SPD_W(SPD_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .rd_done(rd_done), .rd_word(rd_word),
    .start(start), .frame_q(frame_q), .speed_q(speed_q),
    .evt_bit(evt_bit), .mask_bit(mask_bit), .irq(irq)
  );

  mdio_clkgen #(.SPD_W(SPD_W)) u_clk (
    .clk(clk), .rst(rst),
    .load(start), .div_in(speed_q), .run(busy),
    .mdc(mdc), .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  mdio_shifter #(.PRE_BITS(PRE_BITS)) u_shift (
    .clk(clk), .rst(rst),
    .start(start), .frame_in(reg_wdata),
    .tick_rise(tick_rise), .tick_fall(tick_fall), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rd_done(rd_done), .rd_word(rd_word)
  );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int SPD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             irq,
  input logic             mask_bit,
  input logic             evt_bit,
  input logic             done,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      frame_q,
  input logic [SPD_W-1:0] speed_q
);

  assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  assert_out_moves_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  assert_oe_only_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  assert_done_sets_event_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> evt_bit);

  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (done && reg_wr && reg_addr == 2'd1) |=> evt_bit);

  assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mask_bit));

  assert_busy_write_dropped_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && reg_addr == 2'd0) |=> $stable(frame_q[31:16]));

  assert_zero_speed_no_start_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && speed_q == '0) |=> !busy);

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.SPD_W(SPD_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .irq(irq), .mask_bit(mask_bit), .evt_bit(evt_bit),
  .done(done), .reg_wr(reg_wr), .reg_addr(reg_addr), .frame_q(frame_q),
  .speed_q(speed_q)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i, irq;

  always #10 clk = ~clk;

  mdio_mgmt_master u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_spd = 1;
  int rcnt = 0;
  int last_rise = 0;
  logic [15:0] phy_data = 16'h0;
  logic [2:0]  exp_q[$];   // {compare_o, oe, o}

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push_frame(input logic [31:0] f, input bit rd);
    for (int i = 0; i < 64; i++) begin
      if (i < 32)               exp_q.push_back(3'b111);
      else if (rd && i >= 47)   exp_q.push_back(3'b000);
      else                      exp_q.push_back({2'b11, f[63-i]});
    end
    rcnt = 0;
  endtask

  task automatic wait_event();
    logic [31:0] v;
    v = 0;
    for (int n = 0; n < 3000 && v[0] == 1'b0; n++) reg_read(2'd1, v);
  endtask

  // scoreboard monitor and PHY model
  initial begin
    logic pm;
    logic [2:0] e;
    pm = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (mdc && !pm) begin
          if (rcnt > 0) chk("R4", "mdc period", cyc - last_rise, 2 * cur_spd);
          last_rise = cyc;
          if (exp_q.size() == 0) begin
            chk("R9", "unexpected mdc rising edge", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk("R5", "mdio_oe at rising edge", mdio_oe, e[1]);
            if (e[2]) chk("R3", "mdio_o at rising edge", mdio_o, e[0]);
          end
          rcnt++;
        end
        if (!mdc && pm)
          mdio_i = (rcnt >= 48 && rcnt <= 63) ? phy_data[63-rcnt] : 1'b1;
      end
      pm = mdc;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] fa, fb, fc, fd;
    bit seen;
    rst = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 32'd0; mdio_i = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1", "mdc", mdc, 0);
    chk("R1", "mdio_oe", mdio_oe, 0);
    chk("R1", "irq", irq, 0);
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), v);
      chk("R1", "register reset value", v, 0);
    end

    // R2 R3 write frame at speed 3, mask off
    cur_spd = 3;
    reg_write(2'd3, 32'd3);
    fa = {2'b01, 2'b01, 5'd5, 5'd3, 2'b10, 16'hA5C3};
    push_frame(fa, 1'b0);
    reg_write(2'd0, fa);
    wait_event();
    chk("R7", "event after write frame", 1, 1);
    chk("R3", "all bits observed", exp_q.size(), 0);
    chk("R8", "irq with mask off", irq, 0);
    reg_read(2'd0, v);
    chk("R6", "frame word after write frame", v, fa);

    // R7 write 0 keeps, write 1 clears
    reg_write(2'd1, 32'd0);
    reg_read(2'd1, v);
    chk("R7", "event after writing 0", v, 1);
    reg_write(2'd1, 32'd1);
    reg_read(2'd1, v);
    chk("R7", "event after writing 1", v, 0);

    // R5 R6 R10 read frame at speed 1 with a dropped write mid-frame
    reg_write(2'd2, 32'd1);
    cur_spd = 1;
    reg_write(2'd3, 32'd1);
    phy_data = 16'h3C5A;
    fb = {2'b01, 2'b10, 5'h1F, 5'h11, 2'b10, 16'h0000};
    push_frame(fb, 1'b1);
    reg_write(2'd0, fb);
    repeat (20) @(negedge clk);
    reg_write(2'd0, 32'hFFFF_FFFF);
    wait_event();
    @(negedge clk);
    chk("R8", "irq with mask on", irq, 1);
    reg_read(2'd0, v);
    chk("R6", "read data in frame word", v, {fb[31:16], 16'h3C5A});
    chk("R10", "frame completed as first written", exp_q.size(), 0);

    // R11 clear held across completion
    reg_write(2'd1, 32'd1);
    cur_spd = 2;
    reg_write(2'd3, 32'd2);
    phy_data = 16'h0F0F;
    fc = {2'b01, 2'b10, 5'd2, 5'd4, 2'b10, 16'h0000};
    push_frame(fc, 1'b1);
    reg_write(2'd0, fc);
    seen = 1'b0;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd1;
    repeat (64 * 2 * 2 + 60) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    reg_wr = 1'b0;
    chk("R11", "irq pulse while clear held", seen, 1);
    reg_read(2'd1, v);
    chk("R11", "event after clear window", v, 0);
    reg_read(2'd0, v);
    chk("R6", "second read data", v, {fc[31:16], 16'h0F0F});

    // R12 opcode 00 sent fully driven
    fd = {2'b01, 2'b00, 5'd9, 5'd1, 2'b10, 16'h1234};
    push_frame(fd, 1'b0);
    reg_write(2'd0, fd);
    wait_event();
    chk("R12", "opcode 00 frame observed", exp_q.size(), 0);
    reg_write(2'd1, 32'd1);

    // R9 speed zero
    reg_write(2'd3, 32'd0);
    reg_write(2'd0, 32'h6AAA_5555);
    repeat (300) @(negedge clk);
    chk("R9", "mdc idle", mdc, 0);
    reg_read(2'd1, v);
    chk("R9", "no event", v, 0);
    reg_read(2'd0, v);
    chk("R9", "frame word unchanged", v, fd);

    chk("R2", "scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule